// File: doc/BRIEF.md
# Packed Multi-Slot Instruction Sequencer

This block fetches 18-bit instruction words from a small local memory and hands the opcodes packed inside each word to an execute unit, one per cycle. The memory holds 128 words: RAM at 0 to 63 and ROM at 64 to 127. Each word carries three 5-bit opcode slots and one short 3-bit slot. The short slot can only name opcodes whose two low bits are zero. Between words the sequencer spends one fetch cycle, with the word address on its memory port.

Jump opcodes take their destination from the low bits of the word they sit in. This ends the word: no later slot of that word is issued. The execute unit decides whether a jump is taken and reports it on `jump_taken` in the cycle the jump is issued. A stall input lets the execute unit hold the current opcode for as long as it needs.

Top module: `packed_slot_sequencer`

## Requirements
- R1: While reset is held, `issue_valid` is low and `mem_addr` equals the reset address, 64 by default.
- R2: Full slots sit at bits [17:13], [12:8] and [7:3]. They issue in slot order 0, 1, 2, one per cycle, with `issue_slot` naming the slot.
- R3: After slot 2, the short slot at bits [2:0] issues as opcode {bits[2:0], 2'b00} with `issue_slot` = 3.
- R4: The no-op opcode 0x1C takes its own issue cycle, like any other opcode.
- R5: After the last slot, or after a jump, the next cycle is a fetch cycle.
  - In a fetch cycle `issue_valid` is low and `mem_addr` shows the word being read.
  - The next cycle issues slot 0 of that word.
  - The address steps by one within its half, so 127 is followed by 64.
- R6: Opcodes 1, 2 and 3 are jumps and raise `issue_jump`. A jump in slot 0 takes its full 7-bit target from bits [6:0] of its 10-bit field, bits [9:0].
- R7: A jump in slot 1 replaces the low 5 address bits with word bits [4:0]. Address bits [6:5] are kept from the program counter, which already points past the jump's word.
- R8: A jump in slot 2 replaces the low 3 address bits with word bits [2:0]. Address bits [6:3] are kept from the program counter in the same way.
- R9: Once a jump issues, no later slot of its word is issued.
  - If `jump_taken` is high, the next fetch is at the jump target.
  - If `jump_taken` is low, the next fetch is the next sequential word.
- R10: While `issue_stall` is high, the issued opcode and slot stay unchanged and the sequence does not advance. A fetch cycle is held in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 7 | Word address to local memory |
| mem_rdata | input | 18 | Word read combinationally from `mem_addr` |
| issue_stall | input | 1 | Execute unit holds the current step |
| jump_taken | input | 1 | Decision for the jump being issued |
| issue_valid | output | 1 | An opcode is on `issue_op` |
| issue_op | output | 5 | Issued opcode |
| issue_slot | output | 2 | Slot index of the issued opcode |
| issue_jump | output | 1 | Issued opcode is a jump |
| issue_target | output | 7 | Target address of the issued jump |

## Verification
The program exercises each kind of word:
- a word with a no-op and a short slot, which shows the slot order and the short-slot padding;
- jumps in slots 0, 1 and 2, whose targets each keep a different number of high address bits;
- a jump that is not taken, which must fall through to the next word;
- a taken jump to address 127, whose successor must wrap to 64 and not run into RAM.

A stall window checks that the opcode is held. The fetch address stream is compared with its own expected list, so wrong jump targets show up even when the opcodes happen to agree.

// File: rtl/pss_pkg.sv
package pss_pkg;
   localparam int OP_W = 5;
   localparam logic [OP_W-1:0] OP_NOP = 5'h1C;

   function automatic logic op_is_jump(input logic [OP_W-1:0] op);
      return (op[OP_W-1:2] == '0) && (op[1:0] != 2'b00);
   endfunction
endpackage

// File: rtl/pss_pc_step.sv
module pss_pc_step #(
   parameter int PC_W = 7,
   parameter bit HALF_WRAP = 1'b1
) (
   input  logic [PC_W-1:0] pc,
   output logic [PC_W-1:0] pc_next
);
   initial begin
      assert (PC_W >= 2) else $error("pss_pc_step: PC_W too small");
   end

   generate
      if (HALF_WRAP) begin : g_half
         assign pc_next = {pc[PC_W-1], pc[PC_W-2:0] + 1'b1};
      end else begin : g_flat
         assign pc_next = pc + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/pss_unpack.sv
module pss_unpack #(
   parameter int WORD_W = 18,
   parameter int OP_W = 5,
   parameter int SHORT_W = 3,
   parameter int N_FULL = 3,
   parameter int PC_W = 7,
   parameter int JF0 = 10,
   parameter int JF1 = 5,
   parameter int JF2 = 3,
   localparam int SLOT_W = $clog2(N_FULL + 1)
) (
   input  logic [WORD_W-1:0] ir,
   input  logic [SLOT_W-1:0] slot,
   input  logic [PC_W-1:0]   pc,
   output logic [OP_W-1:0]   op,
   output logic              is_jump,
   output logic [PC_W-1:0]   target
);
   function automatic int jf_width(input int k);
      case (k)
         0: return JF0;
         1: return JF1;
         default: return JF2;
      endcase
   endfunction

   initial begin
      assert (N_FULL * OP_W + SHORT_W == WORD_W)
         else $error("pss_unpack: slot widths do not fill the word");
      assert (SHORT_W <= OP_W) else $error("pss_unpack: short slot too wide");
      assert (N_FULL == 3) else $error("pss_unpack: three jump fields defined");
   end

   logic [OP_W-1:0] full_op [N_FULL];
   logic [PC_W-1:0] full_tgt [N_FULL];
   logic [OP_W-1:0] short_op;

   genvar k;
   generate
      for (k = 0; k < N_FULL; k++) begin : g_slot
         localparam int FW = jf_width(k);
         localparam int EW = (FW < PC_W) ? FW : PC_W;
         initial begin
            assert (FW <= WORD_W - (k + 1) * OP_W)
               else $error("pss_unpack: jump field overlaps its own opcode");
         end
         assign full_op[k] = ir[WORD_W-1-k*OP_W -: OP_W];
         if (EW == PC_W) begin : g_whole
            assign full_tgt[k] = ir[PC_W-1:0];
         end else begin : g_merge
            assign full_tgt[k] = {pc[PC_W-1:EW], ir[EW-1:0]};
         end
      end
   endgenerate

   assign short_op = {ir[SHORT_W-1:0], {(OP_W-SHORT_W){1'b0}}};

   always_comb begin
      op     = short_op;
      target = pc;
      for (int i = 0; i < N_FULL; i++) begin
         if (slot == SLOT_W'(i)) begin
            op     = full_op[i];
            target = full_tgt[i];
         end
      end
   end

   assign is_jump = pss_pkg::op_is_jump(op);
endmodule

// File: rtl/packed_slot_sequencer.sv
module packed_slot_sequencer #(
   parameter int WORD_W = 18,
   parameter int OP_W = 5,
   parameter int SHORT_W = 3,
   parameter int N_FULL = 3,
   parameter int PC_W = 7,
   parameter logic [PC_W-1:0] RESET_PC = 7'd64,
   parameter int JF0 = 10,
   parameter int JF1 = 5,
   parameter int JF2 = 3,
   parameter bit HALF_WRAP = 1'b1,
   localparam int SLOT_W = $clog2(N_FULL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [PC_W-1:0]   mem_addr,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              issue_stall,
   input  logic              jump_taken,
   output logic              issue_valid,
   output logic [OP_W-1:0]   issue_op,
   output logic [SLOT_W-1:0] issue_slot,
   output logic              issue_jump,
   output logic [PC_W-1:0]   issue_target
);
   initial begin
      assert (OP_W == pss_pkg::OP_W) else $error("sequencer: OP_W differs from package");
   end

   logic [PC_W-1:0]   pc_q, pc_inc, slot_tgt;
   logic [WORD_W-1:0] ir_q;
   logic [SLOT_W-1:0] slot_q;
   logic              busy_q, slot_jmp;
   logic [OP_W-1:0]   slot_op;

   pss_pc_step #(.PC_W(PC_W), .HALF_WRAP(HALF_WRAP)) u_step (
      .pc(pc_q), .pc_next(pc_inc)
   );

   pss_unpack #(
      .WORD_W(WORD_W), .OP_W(OP_W), .SHORT_W(SHORT_W), .N_FULL(N_FULL),
      .PC_W(PC_W), .JF0(JF0), .JF1(JF1), .JF2(JF2)
   ) u_unpack (
      .ir(ir_q), .slot(slot_q), .pc(pc_q),
      .op(slot_op), .is_jump(slot_jmp), .target(slot_tgt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC;
         ir_q   <= '0;
         slot_q <= '0;
         busy_q <= 1'b0;
      end else if (!issue_stall) begin
         if (!busy_q) begin
            ir_q   <= mem_rdata;
            pc_q   <= pc_inc;
            slot_q <= '0;
            busy_q <= 1'b1;
         end else if (slot_jmp) begin
            busy_q <= 1'b0;
            if (jump_taken) pc_q <= slot_tgt;
         end else if (slot_q == SLOT_W'(N_FULL)) begin
            busy_q <= 1'b0;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   assign mem_addr     = pc_q;
   assign issue_valid  = busy_q;
   assign issue_op     = slot_op;
   assign issue_slot   = slot_q;
   assign issue_jump   = busy_q & slot_jmp;
   assign issue_target = slot_tgt;

   // R10: a stalled issue keeps its opcode and slot
   a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_stall) |=> (issue_valid && $stable(issue_op) && $stable(issue_slot)));

   // R2: a non-jump full slot is followed by the next slot
   a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_stall && !issue_jump && issue_slot != SLOT_W'(N_FULL))
      |=> (issue_valid && issue_slot == $past(issue_slot) + 1'b1));

   // R9: nothing of the word issues after a jump
   a_r9_jump_ends_word: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_jump && !issue_stall) |=> !issue_valid);

   // R5: a fetch cycle leads to slot 0
   a_r5_fetch_slot0: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_valid && !issue_stall) |=> (issue_valid && issue_slot == '0));

   // R5: sequential fetch stays in its half
   a_r5_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_valid && !issue_stall) |=> (mem_addr[PC_W-1] == $past(mem_addr[PC_W-1])));
endmodule

// File: tb/packed_slot_sequencer_bench.sv
`timescale 1ns/1ps
module packed_slot_sequencer_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic issue_stall = 1'b0;
   logic jump_taken;
   logic [6:0] mem_addr;
   logic [17:0] mem_rdata;
   logic issue_valid, issue_jump;
   logic [4:0] issue_op;
   logic [1:0] issue_slot;
   logic [6:0] issue_target;

   logic [17:0] mem [128];
   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [14:0] exp_q [$];
   string tag_q [$];
   logic [6:0] fetch_q [$];

   always #4 clk = ~clk;

   assign mem_rdata = mem[mem_addr];
   // Execute unit model: opcode 3 is a jump never taken, 1 and 2 always taken
   assign jump_taken = issue_valid && (issue_op != 5'd3);

   packed_slot_sequencer u_packed_slot_sequencer (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .issue_stall(issue_stall), .jump_taken(jump_taken),
      .issue_valid(issue_valid), .issue_op(issue_op), .issue_slot(issue_slot),
      .issue_jump(issue_jump), .issue_target(issue_target)
   );

   function automatic logic [17:0] word4(input logic [4:0] a, input logic [4:0] b,
                                         input logic [4:0] c, input logic [2:0] d);
      return {a, b, c, d};
   endfunction

   task automatic push(input logic [4:0] op, input logic [1:0] slot, input bit jmp,
                       input logic [6:0] tgt, input string tag);
      exp_q.push_back({op, slot, tgt, jmp});
      tag_q.push_back(tag);
   endtask

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push_word64();
      push(5'h08, 2'd0, 1'b0, 7'd0, "R2");
      push(5'h0C, 2'd1, 1'b0, 7'd0, "R2");
      push(5'h1C, 2'd2, 1'b0, 7'd0, "R4");
      push(5'h14, 2'd3, 1'b0, 7'd0, "R3");
   endtask

   // Monitor: pops expected items whenever the design advances
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (issue_valid) begin
            if (exp_q.size() > 0) begin
               logic [14:0] e;
               e = exp_q[0];
               if (issue_stall) begin
                  check(issue_op == e[14:10], "R10", {27'd0, issue_op}, {27'd0, e[14:10]});
               end else begin
                  void'(exp_q.pop_front());
                  check({issue_op, issue_slot, issue_jump} == {e[14:8], e[0]},
                        tag_q[0], {24'd0, issue_op, issue_slot, issue_jump},
                        {24'd0, e[14:8], e[0]});
                  if (e[0])
                     check(issue_target == e[7:1], tag_q[0], {25'd0, issue_target},
                           {25'd0, e[7:1]});
                  void'(tag_q.pop_front());
               end
            end
         end else if (fetch_q.size() > 0) begin
            check(mem_addr == fetch_q[0], "R5", {25'd0, mem_addr}, {25'd0, fetch_q[0]});
            if (!issue_stall) void'(fetch_q.pop_front());
         end
      end
   end

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = word4(5'h1C, 5'h1C, 5'h1C, 3'b111);
      mem[64]  = word4(5'h08, 5'h0C, 5'h1C, 3'b101);
      mem[65]  = {5'd1, 3'b000, 10'd10};
      mem[10]  = word4(5'h10, 5'h04, 5'd2, 3'd5);
      mem[13]  = {5'h18, 5'd2, 8'd30};
      mem[30]  = {5'd3, 3'b000, 10'd127};
      mem[31]  = word4(5'h0C, 5'h00, 5'h1C, 3'b000);
      mem[32]  = {5'd1, 3'b000, 10'd127};
      mem[127] = word4(5'h04, 5'h08, 5'h10, 3'b110);

      push_word64();
      push(5'd1, 2'd0, 1'b1, 7'd10, "R6");
      push(5'h10, 2'd0, 1'b0, 7'd0, "R2");
      push(5'h04, 2'd1, 1'b0, 7'd0, "R2");
      push(5'd2, 2'd2, 1'b1, 7'd13, "R8");
      push(5'h18, 2'd0, 1'b0, 7'd0, "R9");
      push(5'd2, 2'd1, 1'b1, 7'd30, "R7");
      push(5'd3, 2'd0, 1'b1, 7'd127, "R6");
      push(5'h0C, 2'd0, 1'b0, 7'd0, "R9");
      push(5'h00, 2'd1, 1'b0, 7'd0, "R2");
      push(5'h1C, 2'd2, 1'b0, 7'd0, "R4");
      push(5'h00, 2'd3, 1'b0, 7'd0, "R3");
      push(5'd1, 2'd0, 1'b1, 7'd127, "R6");
      push(5'h04, 2'd0, 1'b0, 7'd0, "R2");
      push(5'h08, 2'd1, 1'b0, 7'd0, "R2");
      push(5'h10, 2'd2, 1'b0, 7'd0, "R2");
      push(5'h18, 2'd3, 1'b0, 7'd0, "R3");
      push_word64();
      fetch_q = '{7'd64, 7'd65, 7'd10, 7'd13, 7'd30, 7'd31, 7'd32, 7'd127, 7'd64};

      repeat (3) @(posedge clk);
      @(negedge clk);
      check(issue_valid == 1'b0, "R1", {31'd0, issue_valid}, 32'd0);
      check(mem_addr == 7'd64, "R1", {25'd0, mem_addr}, 32'd64);
      @(posedge clk); #1 rst_n = 1'b1;

      repeat (5) @(posedge clk);
      #1 issue_stall = 1'b1;
      repeat (3) @(posedge clk);
      #1 issue_stall = 1'b0;
      repeat (4) @(posedge clk);
      #1 issue_stall = 1'b1;
      repeat (2) @(posedge clk);
      #1 issue_stall = 1'b0;

      while ((exp_q.size() > 0 || fetch_q.size() > 0) && cyc < 2000) @(posedge clk);
      if (exp_q.size() > 0 || fetch_q.size() > 0) begin
         n_chk++;
         n_bad++;
         $display("FAIL R9 actual=%0d expected=0 (items left)", exp_q.size() + fetch_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 5000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<5000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule